// File: doc/BRIEF.md
# Break-aware modulo timer core

This block is a free-running up counter that wraps at a programmable modulo limit and reports each wrap as an overflow event. Next to it sit a parameterised number of channels, each set either to capture (store the count when a synchronised rising edge shows up on its input) or to compare (fire when the count equals its compare register). Every event leaves the block as a one-cycle pulse, and as an interrupt request gated by its own enable. A separate flag block records the pulses.

Three system states reach the timer as plain inputs. A stop request freezes the counter and the registers, and counting resumes from the held value. A debug break also freezes the counter and throws away any capture edges that arrive while it is active. Wait mode leaves the counter running, shuts out the small register port, and still lets interrupt requests through so that they can wake the system.

The register port writes the modulo and compare registers and reads back the count or a captured value. A read returns its data one cycle later, marked by a valid pulse. The port has no back-pressure: a read result is valid for exactly one cycle and has to be taken then.

Top module: `break_modulo_timer`

## Requirements
- R1: While the counter runs, it steps by one each cycle. At the edge where it leaves a value equal to the modulo register it becomes 0 instead, and `ovf_evt` is high for the one cycle after that edge. A modulo value of 0 therefore wraps on every running cycle.
- R2: `ovf_irq` is high exactly when `ovf_evt` is high and `ovf_ie` is high.
- R3: A channel whose `ch_mode` bit is 1 (compare) pulses its `ch_evt` bit for one cycle after a running edge at which the count equals that channel's compare register.
- R4: A channel whose `ch_mode` bit is 0 (capture) passes `cap_in` through two flops and detects a rising edge on the synchronised signal. The detection falls on the third clock edge after the input is first sampled high. At that edge the channel stores the count of the cycle just ending and pulses its `ch_evt` bit for one cycle.
- R5: Each `ch_irq` bit is high exactly when the matching `ch_evt` bit and `ch_ie` bit are both high.
- R6: While `brk_req` is high, the counter holds its value, no overflow or compare events occur, and capture edges are discarded without changing the stored capture value.
- R7: While `stop_req` is high, the counter and all registers hold their values, and no events or captures occur. Counting resumes from the held value.
- R8: While `wait_req` is high, the counter keeps running, writes leave the registers unchanged, and read requests produce no `rd_valid`.
- R9: While `wait_req` is high, overflow and channel interrupt requests still assert according to R2 and R5.
- R10: After reset the count is 0, the modulo register is all ones, the compare and capture registers are 0, and every output is low.
- R11: Register select codes: 0 selects the modulo register on writes and the count on reads. Code k (1 to NCH) selects the compare register (writes) or the capture register (reads) of channel k-1. Other codes write nothing and read 0. When `rd_en` is high in a cycle, `rd_valid` is high in the next cycle, with `rd_data` holding the value seen in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Stop mode: freeze counter and registers |
| brk_req | input | 1 | Debug break: freeze counter, drop captures |
| wait_req | input | 1 | Wait mode: lock out the register port |
| ovf_ie | input | 1 | Overflow interrupt enable |
| ch_mode | input | NCH | Per channel: 1 compare, 0 capture |
| ch_ie | input | NCH | Per-channel interrupt enables |
| cap_in | input | NCH | Asynchronous capture inputs |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | SEL_W | Write register select |
| wr_data | input | CNT_W | Write data |
| rd_en | input | 1 | Read request |
| rd_sel | input | SEL_W | Read register select |
| rd_valid | output | 1 | Read data valid (one cycle) |
| rd_data | output | CNT_W | Read data |
| ovf_evt | output | 1 | Overflow event pulse |
| ovf_irq | output | 1 | Gated overflow interrupt request |
| ch_evt | output | NCH | Channel event pulses |
| ch_irq | output | NCH | Gated channel interrupt requests |

## Verification
A corrupted count shows up within one modulo period as an overflow pulse at the wrong cycle, a compare pulse at the wrong time, or a wrong captured value on the next read. A freeze that lets the count slip shows up on the first overflow after the break or stop ends. A capture synchroniser with the wrong depth moves the capture pulse by a cycle, and the next read of that channel returns a count that is off by one. A write that gets through the wait lockout changes the wrap period from the next cycle on.

// File: rtl/bmt_pkg.sv
package bmt_pkg;
  typedef enum logic {
    CH_CAPTURE = 1'b0,
    CH_COMPARE = 1'b1
  } ch_mode_e;

  localparam int SEL_MOD = 0;

  function automatic int sel_width(input int nch);
    return (nch + 1 <= 2) ? 1 : $clog2(nch + 1);
  endfunction
endpackage

// File: rtl/bmt_counter.sv
module bmt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] mod_val,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf_evt
);
  logic at_limit;

  assign at_limit = (cnt == mod_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      ovf_evt <= 1'b0;
    end else begin
      ovf_evt <= run && at_limit;
      if (run) begin
        if (at_limit) cnt <= '0;
        else          cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/bmt_channel.sv
module bmt_channel
  import bmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             capture_ok,
  input  ch_mode_e         mode,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cap_in,
  output logic [CNT_W-1:0] cap_val,
  output logic             evt
);
  logic sync1, sync2, sync3;
  logic edge_seen, do_cap, do_cmp;

  assign edge_seen = sync2 & ~sync3;
  assign do_cap    = edge_seen && capture_ok && (mode == CH_CAPTURE);
  assign do_cmp    = run && (mode == CH_COMPARE) && (cnt == cmp_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1   <= 1'b0;
      sync2   <= 1'b0;
      sync3   <= 1'b0;
      cap_val <= '0;
      evt     <= 1'b0;
    end else begin
      sync1 <= cap_in;
      sync2 <= sync1;
      sync3 <= sync2;
      evt   <= do_cap || do_cmp;
      if (do_cap) cap_val <= cnt;
    end
  end
endmodule

// File: rtl/bmt_regport.sv
module bmt_regport #(
  parameter int CNT_W = 16,
  parameter int NCH   = 2,
  parameter int SEL_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lock,
  input  logic                 hold,
  input  logic                 wr_en,
  input  logic [SEL_W-1:0]     wr_sel,
  input  logic [CNT_W-1:0]     wr_data,
  input  logic                 rd_en,
  input  logic [SEL_W-1:0]     rd_sel,
  input  logic [CNT_W-1:0]     cnt,
  input  logic [NCH*CNT_W-1:0] cap_flat,
  output logic [CNT_W-1:0]     mod_val,
  output logic [NCH*CNT_W-1:0] cmp_flat,
  output logic                 rd_valid,
  output logic [CNT_W-1:0]     rd_data
);
  logic             wr_ok;
  logic [CNT_W-1:0] rd_mux;

  assign wr_ok = wr_en && !lock && !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mod_val <= '1;
    else if (wr_ok && wr_sel == SEL_W'(0)) mod_val <= wr_data;
  end

  for (genvar k = 0; k < NCH; k++) begin : g_cmp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmp_flat[k*CNT_W +: CNT_W] <= '0;
      else if (wr_ok && wr_sel == SEL_W'(k + 1)) cmp_flat[k*CNT_W +: CNT_W] <= wr_data;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (rd_sel == SEL_W'(0)) rd_mux = cnt;
    for (int k = 0; k < NCH; k++)
      if (rd_sel == SEL_W'(k + 1)) rd_mux = cap_flat[k*CNT_W +: CNT_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en && !lock;
      if (rd_en && !lock) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/break_modulo_timer.sv
module break_modulo_timer
  import bmt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NCH   = 2,
  parameter int SEL_W = bmt_pkg::sel_width(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_req,
  input  logic             brk_req,
  input  logic             wait_req,
  input  logic             ovf_ie,
  input  logic [NCH-1:0]   ch_mode,
  input  logic [NCH-1:0]   ch_ie,
  input  logic [NCH-1:0]   cap_in,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic [SEL_W-1:0] rd_sel,
  output logic             rd_valid,
  output logic [CNT_W-1:0] rd_data,
  output logic             ovf_evt,
  output logic             ovf_irq,
  output logic [NCH-1:0]   ch_evt,
  output logic [NCH-1:0]   ch_irq
);
  logic                 run;
  logic [CNT_W-1:0]     cnt;
  logic [CNT_W-1:0]     mod_val;
  logic [NCH*CNT_W-1:0] cmp_flat;
  logic [NCH*CNT_W-1:0] cap_flat;

  assign run = !stop_req && !brk_req;

  bmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .mod_val(mod_val),
    .cnt(cnt), .ovf_evt(ovf_evt)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    bmt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .run(run), .capture_ok(run),
      .mode(ch_mode_e'(ch_mode[k])),
      .cmp_val(cmp_flat[k*CNT_W +: CNT_W]),
      .cnt(cnt), .cap_in(cap_in[k]),
      .cap_val(cap_flat[k*CNT_W +: CNT_W]),
      .evt(ch_evt[k])
    );
  end

  bmt_regport #(.CNT_W(CNT_W), .NCH(NCH), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .lock(wait_req), .hold(stop_req),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .cnt(cnt), .cap_flat(cap_flat),
    .mod_val(mod_val), .cmp_flat(cmp_flat),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign ovf_irq = ovf_evt & ovf_ie;
  assign ch_irq  = ch_evt & ch_ie;
endmodule

// File: rtl/break_modulo_timer_chk.sv
module break_modulo_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop_req,
  input logic             brk_req,
  input logic             wait_req,
  input logic             rd_valid,
  input logic             ovf_evt,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] mod_val
);
  assert_ovf_wraps_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |-> cnt == '0);
  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_req && !brk_req && cnt != mod_val) |=> cnt == $past(cnt) + CNT_W'(1));
  assert_brk_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |=> cnt == $past(cnt));
  assert_brk_no_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |=> !ovf_evt);
  assert_stop_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> (cnt == $past(cnt)) && (mod_val == $past(mod_val)));
  assert_wait_no_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wait_req |=> !rd_valid);
  assert_wait_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wait_req |=> mod_val == $past(mod_val));
endmodule

bind break_modulo_timer break_modulo_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .brk_req(brk_req),
  .wait_req(wait_req), .rd_valid(rd_valid), .ovf_evt(ovf_evt),
  .cnt(cnt), .mod_val(mod_val)
);

// File: tb/break_modulo_timer_tb.sv
module break_modulo_timer_tb;
  localparam int W = 16;
  localparam int N = 2;
  localparam int S = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req = 1'b1, brk_req = 1'b0, wait_req = 1'b0, ovf_ie = 1'b0;
  logic [N-1:0] ch_mode = '0, ch_ie = '0, cap_in = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [S-1:0] wr_sel = '0, rd_sel = '0;
  logic [W-1:0] wr_data = '0;
  logic rd_valid, ovf_evt, ovf_irq;
  logic [W-1:0] rd_data;
  logic [N-1:0] ch_evt, ch_irq;

  int total = 0, bad = 0, cycles = 0;
  bit checking = 1'b0;

  break_modulo_timer u_dut (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .brk_req(brk_req),
    .wait_req(wait_req), .ovf_ie(ovf_ie), .ch_mode(ch_mode), .ch_ie(ch_ie),
    .cap_in(cap_in), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_valid(rd_valid), .rd_data(rd_data),
    .ovf_evt(ovf_evt), .ovf_irq(ovf_irq), .ch_evt(ch_evt), .ch_irq(ch_irq)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model
  logic [W-1:0] m_cnt, m_mod, m_rdd;
  logic [W-1:0] m_cmp [N];
  logic [W-1:0] m_cap [N];
  logic [N-1:0] m_s1, m_s2, m_s3, m_chev;
  logic m_ovf, m_rdv;

  function automatic logic [W-1:0] next_count(input logic [W-1:0] c, input logic [W-1:0] m, input bit run);
    if (!run) return c;
    return (c == m) ? '0 : c + W'(1);
  endfunction

  function automatic logic [W-1:0] read_value(input logic [S-1:0] sel, input logic [W-1:0] c,
                                              input logic [W-1:0] c0, input logic [W-1:0] c1);
    case (sel)
      2'd0: return c;
      2'd1: return c0;
      2'd2: return c1;
      default: return '0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = '0; m_mod = '1; m_ovf = 0; m_rdv = 0; m_rdd = '0;
      m_s1 = '0; m_s2 = '0; m_s3 = '0; m_chev = '0;
      for (int k = 0; k < N; k++) begin m_cmp[k] = '0; m_cap[k] = '0; end
    end else begin
      bit run;
      logic [W-1:0] oc;
      run = !stop_req && !brk_req;
      oc = m_cnt;
      m_ovf = run && (m_cnt == m_mod);
      m_rdv = rd_en && !wait_req;
      if (m_rdv) m_rdd = read_value(rd_sel, m_cnt, m_cap[0], m_cap[1]);
      for (int k = 0; k < N; k++) begin
        bit cap, cmp;
        cap = m_s2[k] && !m_s3[k] && run && !ch_mode[k];
        cmp = run && ch_mode[k] && (oc == m_cmp[k]);
        m_chev[k] = cap || cmp;
        if (cap) m_cap[k] = oc;
      end
      m_cnt = next_count(oc, m_mod, run);
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = cap_in;
      if (wr_en && !wait_req && !stop_req) begin
        if (wr_sel == 0) m_mod = wr_data;
        else if (wr_sel == 1) m_cmp[0] = wr_data;
        else if (wr_sel == 2) m_cmp[1] = wr_data;
      end
    end
  end

  // continuous comparison, sampled 3 ns after each rising edge
  always begin
    @(posedge clk); #3;
    cycles++;
    if (checking) begin
      chk(ovf_evt == m_ovf, "R1 ovf_evt", ovf_evt, m_ovf);
      chk(ovf_irq == (m_ovf & ovf_ie), "R2 ovf_irq", ovf_irq, m_ovf & ovf_ie);
      chk(ch_evt == m_chev, "R3/R4 ch_evt", ch_evt, m_chev);
      chk(ch_irq == (m_chev & ch_ie), "R5 ch_irq", ch_irq, m_chev & ch_ie);
      chk(rd_valid == m_rdv, "R11 rd_valid", rd_valid, m_rdv);
      if (m_rdv) chk(rd_data == m_rdd, "R11 rd_data", rd_data, m_rdd);
    end
  end

  initial begin
    wait (cycles > 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic do_read(input logic [S-1:0] sel, output logic [W-1:0] val, output logic vld);
    @(negedge clk); rd_en = 1; rd_sel = sel;
    @(negedge clk); rd_en = 0; vld = rd_valid; val = rd_data;
  endtask

  task automatic do_write(input logic [S-1:0] sel, input logic [W-1:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  initial begin
    logic [W-1:0] v, v2;
    logic vld;
    int n;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checking = 1;
    // R10: reset state (stop held so the count stays 0)
    chk(!ovf_evt && !ovf_irq && ch_evt == 0 && ch_irq == 0 && !rd_valid, "R10 outputs", 0, 0);
    do_read(2'd0, v, vld);
    chk(vld && v == 0, "R10 count", v, 0);
    do_read(2'd2, v, vld);
    chk(vld && v == 0, "R10 capture", v, 0);
    do_read(2'd3, v, vld);
    chk(vld && v == 0, "R11 unused select", v, 0);

    // R1: modulo 2 gives three wraps in nine running cycles
    @(negedge clk); stop_req = 0; wr_en = 1; wr_sel = 0; wr_data = 2;
    @(negedge clk); wr_en = 0; stop_req = 1;
    do_read(2'd0, v, vld);
    @(negedge clk); stop_req = 0;
    n = 0;
    repeat (9) begin @(posedge clk); #3; if (ovf_evt) n++; end
    @(negedge clk); stop_req = 1;
    chk(n == 3, "R1 wrap count", n, 3);

    // R7: count held across stop
    do_read(2'd0, v, vld);
    repeat (5) @(negedge clk);
    do_read(2'd0, v2, vld);
    chk(v == v2, "R7 hold in stop", v2, v);

    // R6: capture edge during break is dropped
    stop_req = 0; brk_req = 1; ch_mode = 2'b00; ch_ie = 2'b11;
    @(negedge clk); cap_in[0] = 1;
    n = 0;
    repeat (6) begin @(posedge clk); #3; if (ch_evt[0]) n++; end
    chk(n == 0, "R6 capture suppressed", n, 0);
    do_read(2'd1, v, vld);
    chk(v == 0, "R6 capture unchanged", v, 0);
    @(negedge clk); brk_req = 0; cap_in[0] = 0;

    // R4: capture outside break
    @(negedge clk); cap_in[1] = 1;
    n = 0;
    repeat (4) begin @(posedge clk); #3; if (ch_evt[1]) n++; end
    chk(n == 1, "R4 capture pulse", n, 1);

    // R8: reads locked in wait, count keeps running
    @(negedge clk); wait_req = 1; rd_en = 1; rd_sel = 0;
    @(negedge clk); rd_en = 0;
    chk(!rd_valid, "R8 read ignored", rd_valid, 0);
    wait_req = 0;

    // constrained random phase, with R9 covered whenever wait overlaps an event
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if ($urandom % 10 == 0) stop_req = ~stop_req & ($urandom % 3 == 0);
      if ($urandom % 10 == 0) brk_req  = ~brk_req & ($urandom % 3 == 0);
      if ($urandom % 8 == 0)  wait_req = ~wait_req;
      if ($urandom % 4 == 0)  cap_in = N'($urandom);
      if ($urandom % 50 == 0) ch_mode = N'($urandom);
      if ($urandom % 20 == 0) ch_ie = N'($urandom);
      if ($urandom % 20 == 0) ovf_ie = ~ovf_ie;
      wr_en = ($urandom % 12 == 0);
      wr_sel = S'($urandom % 3);
      wr_data = W'($urandom % 40);
      rd_en = ($urandom % 4 == 0);
      rd_sel = S'($urandom);
    end
    @(negedge clk); wr_en = 0; rd_en = 0;
    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule